// File: doc/BRIEF.md
# Clos Network Path Allocator

This block is the path-selection control for a three-stage Clos(N,n,k) circuit switch. The fabric has N/n ingress switches of n×k, k middle switches of (N/n)×(N/n) and N/n egress switches of k×n. A port p belongs to the ingress or egress switch numbered p / n (integer division). A connect request names an input port and an output port. The allocator looks for a middle switch whose link from the input's ingress switch is free and whose link to the output's egress switch is also free. It records the call and answers with the chosen middle index. A release request names a connected input, frees both links of its path and frees the two ports.

The allocator keeps one k-bit occupancy vector for each ingress switch and one for each egress switch. It also keeps a per-input record of the middle switch and the output that the call uses. Search and commit take one cycle. The response is registered and appears in the cycle after the request. With k ≥ 2n−1 the fabric is strict-sense non-blocking, so a request for an idle pair always finds a path. With smaller k a request can find no common free middle switch, and the allocator then reports a blocked call. The default build is Clos(8,2,3).

Top module: `clos_path_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid is 0. After reset every port is idle and every link is free, so the first connect succeeds on middle switch 0.
- R2: Each cycle with req_valid high produces exactly one response in the next cycle, and a cycle without a request produces none. A response raises exactly one of rsp_ok, rsp_err and rsp_block.
- R3: A connect (req_op = 0) on an idle input and an idle output succeeds only on a middle switch m whose link (ingress switch req_in / n, m) and link (m, egress switch req_out / n) are both free. It returns m on rsp_mid and marks both links, the input and the output busy.
- R4: When several middle switches qualify, the lowest index is chosen.
- R5: A connect whose input or output is already in use returns rsp_err and changes no state.
- R6: A connect on idle ports with no common free middle switch returns rsp_block and changes no state.
- R7: When N_MIDS ≥ 2·GRP_SIZE − 1, a connect on an idle input and an idle output is never blocked, whatever calls are in place.
- R8: A release (req_op = 1) of a connected input returns rsp_ok with the middle index the call used. It frees that middle switch's link on the ingress side and on the egress side, and it frees the input and its recorded output.
- R9: A release of an idle input returns rsp_err and changes no state. req_out has no effect on a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = connect, 1 = release |
| req_in | input | $clog2(N_PORTS) | Input port of the call |
| req_out | input | $clog2(N_PORTS) | Output port (connect only) |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Connect committed or release done |
| rsp_err | output | 1 | Port state conflict |
| rsp_block | output | 1 | No common free middle switch |
| rsp_mid | output | $clog2(N_MIDS) | Chosen or released middle index, 0 otherwise |

## Verification
The bench checks the choice of the lowest qualifying middle switch when several are free. A design that scanned from the top, or ignored one side's links, would return the wrong index or a middle switch already in use. A long run of random connects and releases on the 8-port default must never see a blocked call, and a release must hand back the exact middle index of the call. A stale link bit left after release would show up later as a wrong index or a spurious block. A second instance built as Clos(4,2,2) is driven into a real blocking state. There a design that committed anyway would succeed where a block is expected, and one that updated state on a block would change the answers that follow. Repeated connects, repeated releases and releases with a junk output port catch a design that corrupts its records on an error.

// File: rtl/clos_pkg.sv
package clos_pkg;
  typedef enum logic {
    OP_CONNECT = 1'b0,
    OP_RELEASE = 1'b1
  } clos_op_e;
endpackage

// File: rtl/clos_mid_pick.sv
module clos_mid_pick #(
  parameter int N_MIDS = 3,
  localparam int MW = (N_MIDS > 1) ? $clog2(N_MIDS) : 1
) (
  input  logic [N_MIDS-1:0] free_i,
  output logic              found_o,
  output logic [MW-1:0]     idx_o
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int m = N_MIDS - 1; m >= 0; m--) begin
      if (free_i[m]) begin
        found_o = 1'b1;
        idx_o   = MW'(m);
      end
    end
  end
endmodule

// File: rtl/clos_link_map.sv
module clos_link_map #(
  parameter int N_GRPS = 4,
  parameter int N_MIDS = 3,
  localparam int GW = (N_GRPS > 1) ? $clog2(N_GRPS) : 1,
  localparam int MW = (N_MIDS > 1) ? $clog2(N_MIDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GW-1:0]     look_ig_i,
  input  logic [GW-1:0]     look_eg_i,
  output logic [N_MIDS-1:0] ig_free_o,
  output logic [N_MIDS-1:0] eg_free_o,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [GW-1:0]     upd_ig_i,
  input  logic [GW-1:0]     upd_eg_i,
  input  logic [MW-1:0]     upd_mid_i
);
  logic [N_MIDS-1:0] ig_busy [N_GRPS];
  logic [N_MIDS-1:0] eg_busy [N_GRPS];

  for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ig_busy[g] <= '0;
        eg_busy[g] <= '0;
      end else begin
        if (upd_ig_i == GW'(g)) begin
          if (set_i) ig_busy[g][upd_mid_i] <= 1'b1;
          else if (clr_i) ig_busy[g][upd_mid_i] <= 1'b0;
        end
        if (upd_eg_i == GW'(g)) begin
          if (set_i) eg_busy[g][upd_mid_i] <= 1'b1;
          else if (clr_i) eg_busy[g][upd_mid_i] <= 1'b0;
        end
      end
    end
  end

  assign ig_free_o = ~ig_busy[look_ig_i];
  assign eg_free_o = ~eg_busy[look_eg_i];
endmodule

// File: rtl/clos_port_book.sv
module clos_port_book #(
  parameter int N_PORTS = 8,
  parameter int N_MIDS  = 3,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int MW = (N_MIDS > 1) ? $clog2(N_MIDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] q_in_i,
  input  logic [PW-1:0] q_out_i,
  output logic          in_busy_o,
  output logic          out_busy_o,
  output logic [MW-1:0] rec_mid_o,
  output logic [PW-1:0] rec_dst_o,
  input  logic          commit_i,
  input  logic          release_i,
  input  logic [MW-1:0] commit_mid_i
);
  logic [N_PORTS-1:0] in_busy;
  logic [N_PORTS-1:0] out_busy;
  logic [MW-1:0]      mid_q [N_PORTS];
  logic [PW-1:0]      dst_q [N_PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_busy  <= '0;
      out_busy <= '0;
      for (int p = 0; p < N_PORTS; p++) begin
        mid_q[p] <= '0;
        dst_q[p] <= '0;
      end
    end else if (commit_i) begin
      in_busy[q_in_i]   <= 1'b1;
      out_busy[q_out_i] <= 1'b1;
      mid_q[q_in_i]     <= commit_mid_i;
      dst_q[q_in_i]     <= q_out_i;
    end else if (release_i) begin
      in_busy[q_in_i]         <= 1'b0;
      out_busy[dst_q[q_in_i]] <= 1'b0;
    end
  end

  assign in_busy_o  = in_busy[q_in_i];
  assign out_busy_o = out_busy[q_out_i];
  assign rec_mid_o  = mid_q[q_in_i];
  assign rec_dst_o  = dst_q[q_in_i];
endmodule

// File: rtl/clos_path_alloc.sv
module clos_path_alloc #(
  parameter int N_PORTS  = 8,
  parameter int GRP_SIZE = 2,
  parameter int N_MIDS   = 3,
  localparam int N_GRPS = N_PORTS / GRP_SIZE,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int GW = (N_GRPS > 1) ? $clog2(N_GRPS) : 1,
  localparam int MW = (N_MIDS > 1) ? $clog2(N_MIDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [PW-1:0] req_in,
  input  logic [PW-1:0] req_out,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_err,
  output logic          rsp_block,
  output logic [MW-1:0] rsp_mid
);
  import clos_pkg::*;

  function automatic logic [GW-1:0] grp_of(input logic [PW-1:0] p);
    logic [PW-1:0] q;
    q = p / PW'(GRP_SIZE);
    return q[GW-1:0];
  endfunction

  logic          in_busy, out_busy;
  logic [MW-1:0] rec_mid;
  logic [PW-1:0] rec_dst;
  logic [N_MIDS-1:0] ig_free, eg_free, both_free;
  logic          pick_found;
  logic [MW-1:0] pick_idx;

  // named internal events, brought out for the checker
  logic is_conn, is_rel;
  logic conn_err, conn_blk, rel_err;
  logic ev_commit, ev_release;

  assign is_conn = req_valid && (req_op == OP_CONNECT);
  assign is_rel  = req_valid && (req_op == OP_RELEASE);

  assign conn_err   = is_conn && (in_busy || out_busy);
  assign conn_blk   = is_conn && !conn_err && !pick_found;
  assign ev_commit  = is_conn && !conn_err && pick_found;
  assign rel_err    = is_rel && !in_busy;
  assign ev_release = is_rel && in_busy;

  assign both_free = ig_free & eg_free;

  clos_port_book #(.N_PORTS(N_PORTS), .N_MIDS(N_MIDS)) book_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_in_i       (req_in),
    .q_out_i      (req_out),
    .in_busy_o    (in_busy),
    .out_busy_o   (out_busy),
    .rec_mid_o    (rec_mid),
    .rec_dst_o    (rec_dst),
    .commit_i     (ev_commit),
    .release_i    (ev_release),
    .commit_mid_i (pick_idx)
  );

  clos_link_map #(.N_GRPS(N_GRPS), .N_MIDS(N_MIDS)) links_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_ig_i (grp_of(req_in)),
    .look_eg_i (grp_of(req_out)),
    .ig_free_o (ig_free),
    .eg_free_o (eg_free),
    .set_i     (ev_commit),
    .clr_i     (ev_release),
    .upd_ig_i  (grp_of(req_in)),
    .upd_eg_i  (ev_commit ? grp_of(req_out) : grp_of(rec_dst)),
    .upd_mid_i (ev_commit ? pick_idx : rec_mid)
  );

  clos_mid_pick #(.N_MIDS(N_MIDS)) pick_i (
    .free_i  (both_free),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_block <= 1'b0;
      rsp_mid   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= ev_commit || ev_release;
      rsp_err   <= conn_err || rel_err;
      rsp_block <= conn_blk;
      rsp_mid   <= ev_commit ? pick_idx : (ev_release ? rec_mid : '0);
    end
  end
endmodule

// File: rtl/clos_path_alloc_chk.sv
module clos_path_alloc_chk #(
  parameter int N_MIDS   = 3,
  parameter int GRP_SIZE = 2,
  localparam int MW = (N_MIDS > 1) ? $clog2(N_MIDS) : 1,
  localparam bit NONBLOCK = (N_MIDS >= 2 * GRP_SIZE - 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          rsp_err,
  input logic          rsp_block,
  input logic [MW-1:0] rsp_mid,
  input logic          ev_commit,
  input logic          ev_release
);
  // R2
  rsp_one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_err, rsp_block}) == 1));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_ok || rsp_err || rsp_block));

  // R7
  never_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NONBLOCK && rsp_valid) |-> !rsp_block);

  // R3
  mid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> ({{(32-MW){1'b0}}, rsp_mid} < N_MIDS));

  // R3
  commit_reports_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (rsp_valid && rsp_ok));

  // R8
  release_reports_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (rsp_valid && rsp_ok));
endmodule

bind clos_path_alloc clos_path_alloc_chk #(.N_MIDS(N_MIDS), .GRP_SIZE(GRP_SIZE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_ok     (rsp_ok),
  .rsp_err    (rsp_err),
  .rsp_block  (rsp_block),
  .rsp_mid    (rsp_mid),
  .ev_commit  (ev_commit),
  .ev_release (ev_release)
);

// File: tb/clos_path_alloc_tb_top.sv
module clos_path_alloc_tb_top;
  localparam int N  = 8;
  localparam int G  = 2;
  localparam int K  = 3;
  localparam int PW = $clog2(N);
  localparam int MW = $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // ---------------- main DUT: Clos(8,2,3)
  logic          req_valid = 1'b0, req_op = 1'b0;
  logic [PW-1:0] req_in = '0, req_out = '0;
  logic          rsp_valid, rsp_ok, rsp_err, rsp_block;
  logic [MW-1:0] rsp_mid;

  clos_path_alloc #(.N_PORTS(N), .GRP_SIZE(G), .N_MIDS(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_in(req_in), .req_out(req_out), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_block(rsp_block), .rsp_mid(rsp_mid)
  );

  // ---------------- blocking DUT: Clos(4,2,2)
  logic       b_valid = 1'b0, b_op = 1'b0;
  logic [1:0] b_in = '0, b_out = '0;
  logic       b_rv, b_ok, b_err, b_blk;
  logic       b_mid;

  clos_path_alloc #(.N_PORTS(4), .GRP_SIZE(2), .N_MIDS(2)) blk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_op(b_op),
    .req_in(b_in), .req_out(b_out), .rsp_valid(b_rv),
    .rsp_ok(b_ok), .rsp_err(b_err), .rsp_block(b_blk), .rsp_mid(b_mid)
  );

  // ---------------- reference model (call list view)
  bit m_in_busy [N];
  bit m_out_busy[N];
  int m_mid     [N];
  int m_dst     [N];

  function automatic bit link_taken(bit egress, int grp, int mid);
    for (int p = 0; p < N; p++)
      if (m_in_busy[p] && m_mid[p] == mid && ((egress ? m_dst[p] : p) / G) == grp)
        return 1'b1;
    return 1'b0;
  endfunction

  // expected item: {ok, err, blk, mid}
  int    exp_q[$];
  string tag_q[$];

  function automatic int pack_exp(bit ok, bit err, bit blk, int mid);
    return (int'(ok) << 10) | (int'(err) << 9) | (int'(blk) << 8) | mid;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // driver: compute expectation, update model, drive request
  task automatic send(bit op, int in, int out, string tag);
    int e;
    @(negedge clk);
    if (op == 1'b0) begin
      if (m_in_busy[in] || m_out_busy[out]) e = pack_exp(0, 1, 0, 0);
      else begin
        int pick = -1;
        for (int m = K - 1; m >= 0; m--)
          if (!link_taken(0, in / G, m) && !link_taken(1, out / G, m)) pick = m;
        if (pick < 0) e = pack_exp(0, 0, 1, 0);
        else begin
          e = pack_exp(1, 0, 0, pick);
          m_in_busy[in] = 1'b1; m_out_busy[out] = 1'b1;
          m_mid[in] = pick; m_dst[in] = out;
        end
      end
    end else begin
      if (!m_in_busy[in]) e = pack_exp(0, 1, 0, 0);
      else begin
        e = pack_exp(1, 0, 0, m_mid[in]);
        m_in_busy[in] = 1'b0; m_out_busy[m_dst[in]] = 1'b0;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_op = op; req_in = PW'(in); req_out = PW'(out);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fail("R2", "unexpected response", 1, 0);
      end else begin
        int e;
        string t;
        int act;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = pack_exp(rsp_ok, rsp_err, rsp_block, int'(rsp_mid));
        checks++;
        if (act != e) fail(t, "{ok,err,blk,mid}", act, e);
        // R7: the theory says the default build never blocks
        if (e[8]) begin
          checks++;
          fail("R7", "model predicted block", 1, 0);
        end
      end
    end
  end

  task automatic bsend(bit op, int in, int out, bit eok, bit eerr, bit eblk, int emid, string tag);
    @(negedge clk);
    b_valid = 1'b1; b_op = op; b_in = 2'(in); b_out = 2'(out);
    @(negedge clk);
    b_valid = 1'b0;
    checks++;
    if (!b_rv || b_ok != eok || b_err != eerr || b_blk != eblk || int'(b_mid) != emid)
      fail(tag, "blk {v,ok,err,blk,mid}",
           (int'(b_rv) << 16) | pack_exp(b_ok, b_err, b_blk, int'(b_mid)),
           (1 << 16) | pack_exp(eok, eerr, eblk, emid));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fail("watchdog", "run hung", 1, 0);
    finish_run();
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      m_in_busy[p] = 0; m_out_busy[p] = 0; m_mid[p] = 0; m_dst[p] = 0;
    end
    repeat (4) @(negedge clk);
    checks++;
    if (rsp_valid || b_rv) fail("R1", "rsp_valid in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid) fail("R1", "rsp_valid after reset", 1, 0);

    // R1: fresh state -> mid 0
    send(0, 0, 0, "R1 first connect");
    // R5: busy input / busy output
    send(0, 0, 5, "R5 input in use");
    send(0, 4, 0, "R5 output in use");
    // R3/R4: side constraints and lowest index
    send(0, 1, 2, "R3 ingress link busy");
    send(0, 2, 1, "R3 egress link busy");
    send(0, 3, 3, "R4 lowest free");
    send(0, 5, 6, "R4 lowest free idle groups");
    // R8/R9: release, double release, junk output on release
    send(1, 1, 7, "R8 release returns mid");
    send(1, 1, 0, "R9 release idle input");
    send(0, 1, 2, "R8 freed links reused");
    send(1, 0, 3, "R9 release ignores req_out");
    send(0, 6, 0, "R8 freed output reusable");
    idle(3);

    // R7: random stress
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 55) begin
        int a, b;
        a = int'($urandom_range(0, N - 1));
        b = int'($urandom_range(0, N - 1));
        for (int s = 0; s < N; s++) if (m_in_busy[a]) a = (a + 1) % N;
        for (int s = 0; s < N; s++) if (m_out_busy[b]) b = (b + 1) % N;
        send(0, a, b, "R7 stress connect");
      end else if (r < 95) begin
        int a;
        a = int'($urandom_range(0, N - 1));
        for (int s = 0; s < N; s++) if (!m_in_busy[a]) a = (a + 1) % N;
        send(1, a, int'($urandom_range(0, N - 1)), "R8 stress release");
      end else begin
        send(0, int'($urandom_range(0, N - 1)), int'($urandom_range(0, N - 1)),
             "R5 stress any connect");
      end
      if (($urandom_range(0, 7)) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) fail("R2", "missing responses", exp_q.size(), 0);

    // R6: Clos(4,2,2) blocking case
    bsend(0, 2, 2, 1, 0, 0, 0, "R6 setup a");
    bsend(0, 3, 3, 1, 0, 0, 1, "R6 setup b");
    bsend(1, 2, 0, 1, 0, 0, 0, "R6 setup release");
    bsend(0, 0, 0, 1, 0, 0, 0, "R6 setup c");
    bsend(0, 1, 2, 0, 0, 1, 0, "R6 blocked");
    bsend(0, 1, 2, 0, 0, 1, 0, "R6 block leaves state");
    bsend(1, 3, 1, 1, 0, 0, 1, "R6 release egress m1");
    bsend(0, 1, 2, 1, 0, 0, 1, "R6 now routable");
    bsend(0, 2, 3, 1, 0, 0, 0, "R6 output of blocked call was free");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule